// File: doc/BRIEF.md
# Condition Flag and Branch Resolve Unit

This unit observes the value on a shared data bus and classifies it as negative, zero or positive when read as a two's-complement word. The classification is held in a three-bit flag register that is written only when the controlling sequencer raises a flag-load strobe. Instructions that do not produce a result leave the strobe low, so the register keeps its previous contents.

From the held flags the unit also resolves a conditional branch. A three-bit select field taken from the branch instruction is combined with the held flags, and the branch is taken when a selected flag is set. The width of the bus is a parameter and defaults to 16 bits.

Top module: `ccr_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flags become neg=0, zero=1, pos=0.
- R2: When `cc_load` is high at a rising edge, the flags take the class of `bus_val`: neg=1 when the most significant bit is 1.
- R3: On a load, zero=1 when every bit of `bus_val` is 0.
- R4: On a load, pos=1 when the most significant bit is 0 and at least one bit is 1.
- R5: When `cc_load` is low, the flags keep their value whatever `bus_val` carries.
- R6: Exactly one of neg, zero, pos is high in every cycle.
- R7: `take_branch` is high when (`br_sel[2]` & neg) | (`br_sel[1]` & zero) | (`br_sel[0]` & pos). The three bits of `br_sel` select, in order, negative, zero and positive.
- R8: `br_sel`=3'b000 never takes the branch. `br_sel`=3'b111 always takes it.
- R9: `take_branch` is combinational from the held flags. In a cycle with a load, it uses the flags held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_val | input | 16 | Value currently on the shared bus |
| cc_load | input | 1 | Flag-load strobe |
| br_sel | input | 3 | Branch condition select {n,z,p} |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| flag_p | output | 1 | Held positive flag |
| take_branch | output | 1 | Branch resolution |

## Verification
The hardest case to reach is a load and a branch test in the same cycle, where the branch must see the old flags. The bench sets up a known flag state. In one cycle it then raises `cc_load` with a bus value of a different class and drives a select that matches only the old flag. It samples `take_branch` before the edge and the flags after the edge. The sweep covers every select against each of the three flag states, and the bus values include the extreme words 0x8000, 0x7FFF, 0xFFFF and 0x0001.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

    function automatic cc_flags_t classify(input logic sign, input logic nonzero);
        cc_flags_t f;
        f.neg  = sign;
        f.zero = ~nonzero;
        f.pos  = ~sign & nonzero;
        return f;
    endfunction
endpackage

// File: rtl/ccr_classify.sv
module ccr_classify
    import ccr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output cc_flags_t    cls
);
    localparam int MSB = W - 1;
    always_comb cls = classify(value[MSB], |value);
endmodule

// File: rtl/ccr_branch.sv
module ccr_branch
    import ccr_pkg::*;
(
    input  cc_flags_t  flags,
    input  logic [2:0] sel,
    output logic       taken
);
    always_comb taken = (sel[2] & flags.neg) | (sel[1] & flags.zero) | (sel[0] & flags.pos);
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_val,
    input  logic         cc_load,
    input  logic [2:0]   br_sel,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_p,
    output logic         take_branch
);
    cc_flags_t cls, held;

    ccr_classify #(.W(W)) u_cls (.value(bus_val), .cls(cls));

    always_ff @(posedge clk) begin
        if (rst)          held <= CC_RESET;
        else if (cc_load) held <= cls;
    end

    ccr_branch u_br (.flags(held), .sel(br_sel), .taken(take_branch));

    assign flag_n = held.neg;
    assign flag_z = held.zero;
    assign flag_p = held.pos;

    assert_reset_R1: assert property (@(posedge clk) rst |=> (flag_z && !flag_n && !flag_p));
    assert_neg_R2: assert property (@(posedge clk) disable iff (rst)
        (cc_load && bus_val[W-1]) |=> flag_n);
    assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cc_load && bus_val == '0) |=> flag_z);
    assert_pos_R4: assert property (@(posedge clk) disable iff (rst)
        (cc_load && !bus_val[W-1] && bus_val != '0) |=> flag_p);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cc_load |=> $stable({flag_n, flag_z, flag_p}));
    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_n, flag_z, flag_p}) == 1);
    assert_never_R8: assert property (@(posedge clk) disable iff (rst)
        (br_sel == 3'b000) |-> !take_branch);
    assert_always_R8: assert property (@(posedge clk) disable iff (rst)
        (br_sel == 3'b111) |-> take_branch);
endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb;
    logic clk = 0;
    logic rst;
    logic [15:0] bus_val;
    logic cc_load;
    logic [2:0] br_sel;
    logic flag_n, flag_z, flag_p, take_branch;
    int tests = 0, fails = 0;
    logic [2:0] exp_f;

    always #4 clk = ~clk;

    ccr_unit u_dut (.clk(clk), .rst(rst), .bus_val(bus_val), .cc_load(cc_load),
        .br_sel(br_sel), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
        .take_branch(take_branch));

    function automatic logic [2:0] cls(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'd0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] v);
        bus_val = v; cc_load = 1;
        @(posedge clk); #1; cc_load = 0;
        exp_f = cls(v);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hA5A5, 16'h0000};
        rst = 1; cc_load = 0; bus_val = 16'hFFFF; br_sel = 0;
        @(posedge clk); #1; rst = 0;
        chk("R1", {flag_n, flag_z, flag_p}, 3'b010);
        exp_f = 3'b010;
        // R2 R3 R4 loads over extreme and mixed values
        foreach (vals[i]) begin
            load(vals[i]);
            chk(exp_f[2] ? "R2" : exp_f[1] ? "R3" : "R4", {flag_n, flag_z, flag_p}, exp_f);
            chk("R6", 3'($countones({flag_n, flag_z, flag_p})), 3'd1);
            // R5: bus changes without load
            for (int k = 0; k < 4; k++) begin
                bus_val = 16'h4000 * k[15:0] + 16'h8001;
                @(posedge clk); #1;
                chk("R5", {flag_n, flag_z, flag_p}, exp_f);
            end
            // R7 R8 all selects against current flags
            for (int s = 0; s < 8; s++) begin
                br_sel = s[2:0]; #1;
                chk(s == 0 || s == 7 ? "R8" : "R7", {2'b0, take_branch}, {2'b0, |(s[2:0] & exp_f)});
            end
        end
        // R9: same-cycle load and branch use old flags
        load(16'h0005);
        bus_val = 16'h8000; cc_load = 1; br_sel = 3'b001; #1;
        chk("R9", {2'b0, take_branch}, 3'b001);
        br_sel = 3'b100; #1;
        chk("R9", {2'b0, take_branch}, 3'b000);
        @(posedge clk); #1; cc_load = 0;
        chk("R9", {2'b0, take_branch}, 3'b001);
        chk("R2", {flag_n, flag_z, flag_p}, 3'b100);
        // R1 reset again from a nonzero state
        rst = 1; @(posedge clk); #1; rst = 0;
        chk("R1", {flag_n, flag_z, flag_p}, 3'b010);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule